// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of an asynchronous DRAM refreshed inside its retention window. A free-running interval timer produces one refresh obligation per `CLK_PER_REF` clock cycles, and a saturating debt counter records how many obligations are outstanding. While any debt remains, the block raises a request to the access controller. When the controller grants the bus, the block runs one refresh cycle and then releases the bus. If debt is still owed and the grant is still held, it runs the next cycle straight away.

The refresh style is fixed at build time. In the default style, CAS is taken low before RAS, and the DRAM supplies the row from its own internal counter, so the address lines carry zero. In the alternative style, the block keeps its own row counter. It places that row on the address lines and pulses RAS while CAS stays high. The strobe and address outputs feed the access controller's pin multiplexer, and `refBusy` is the select for that multiplexer. Outside a refresh, the strobes rest high and the address rests at zero.

A page burst can hold off the grant for several intervals. Refreshes missed in that time are kept as debt, up to `DEBT_MAX`, and are run back to back once the grant arrives.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and after its release, `rasN` and `casN` are 1, and `refBusy`, `refReq` and `addr` are 0.
- R2: `refReq` first rises exactly `CLK_PER_REF` clock edges after reset release. Each further interval adds one refresh of debt, one every `CLK_PER_REF` edges.
- R3: Debt saturates at `DEBT_MAX`. After more intervals than that elapse without a grant, exactly `DEBT_MAX` refreshes run before `refReq` falls.
- R4: In the CAS-before-RAS style, `casN` goes low `SETUP_CYC` cycles before `rasN` goes low. It stays low for `CAS_HOLD_CYC` cycles after `rasN` goes low.
- R5: `refBusy` rises one cycle after the edge that samples the grant with debt owed. `rasN` is low for `RAS_CYC` cycles. Both strobes are then high for `PRECHG_CYC` cycles before `refBusy` falls.
- R6: In the CAS-before-RAS style, `addr` stays at 0 throughout.
- R7: In the RAS-only style, `casN` stays high. While `rasN` is low, `addr` holds the row counter value, zero-extended from `ROW_W` bits and held stable.
- R8: In the RAS-only style, the row counter starts at 0 and advances by one after each refresh. It wraps from 2^`ROW_W`-1 to 0.
- R9: `refReq` is high whenever debt is nonzero. Each completed refresh reduces the debt by one. While the grant is held, refreshes follow one another until the debt is zero, with one idle cycle between them.
- R10: If an interval expires on the same edge as a refresh completes, the debt is unchanged by that edge.
- R11: Whenever `refBusy` is 0, `rasN` and `casN` are 1 and `addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Bus grant from the access controller; held while refBusy is high |
| refReq | output | 1 | Refresh owed (debt nonzero) |
| refBusy | output | 1 | Block owns the DRAM pins; mux select for the controller |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| addr | output | ADDR_W | Row address (RAS-only style) or zero |

## Verification
The interval expiry and the completion of a refresh can land on the same clock edge. One increments the debt and the other decrements it. The bench creates this collision by letting two intervals of debt build up and then asserting the grant exactly five edges before the third interval expires, so that the rising edge of RAS coincides with the new debt. The collision is judged correct if exactly three refreshes then run before the request drops. The same refresh is checked cycle by cycle against a table of the expected strobe waveform.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RAS   = 2'd2,
    ST_PRE   = 2'd3
  } refState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseClr;   // restart the in-state cycle counter
    logic rasLow;     // next rasN value is low
    logic casLow;     // next casN value is low
    logic driveAddr;  // place the row on the address output
    logic busy;       // block owns the pins
    logic done;       // refresh completes on this edge
  } refStrobe_t;

endpackage

// File: rtl/dram_ref_ctrl.sv
module dram_ref_ctrl
  import dram_ref_pkg::*;
#(
  parameter int SETUP_CYC    = 2,
  parameter int RAS_CYC      = 3,
  parameter int CAS_HOLD_CYC = 1,
  parameter int PRECHG_CYC   = 3,
  parameter bit RAS_ONLY     = 1'b0,
  parameter int PH_W         = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refGrant,
  input  logic            owed,
  input  logic [PH_W-1:0] phase,
  output refStrobe_t      strb
);

  localparam logic [PH_W-1:0] SETUP_LAST = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0] RAS_LAST   = PH_W'(RAS_CYC - 1);
  localparam logic [PH_W-1:0] PRE_LAST   = PH_W'(PRECHG_CYC - 1);
  localparam logic [PH_W-1:0] CAS_HOLD   = PH_W'(CAS_HOLD_CYC);

  refState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt      = state;
    strb.phaseClr = 1'b0;
    strb.done     = 1'b0;
    unique case (state)
      ST_IDLE: if (refGrant && owed) begin
        stateNxt      = ST_SETUP;
        strb.phaseClr = 1'b1;
      end
      ST_SETUP: if (phase == SETUP_LAST) begin
        stateNxt      = ST_RAS;
        strb.phaseClr = 1'b1;
      end
      ST_RAS: if (phase == RAS_LAST) begin
        stateNxt      = ST_PRE;
        strb.phaseClr = 1'b1;
        strb.done     = 1'b1;
      end
      ST_PRE: if (phase == PRE_LAST) begin
        stateNxt      = ST_IDLE;
        strb.phaseClr = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // pin levels for the cycle after this edge
  always_comb begin
    strb.busy      = (state != ST_IDLE);
    strb.rasLow    = (state == ST_RAS);
    strb.driveAddr = (state == ST_SETUP) || (state == ST_RAS);
    if (RAS_ONLY)
      strb.casLow = 1'b0;
    else
      strb.casLow = (state == ST_SETUP) ||
                    ((state == ST_RAS) && (phase < CAS_HOLD));
  end

endmodule

// File: rtl/dram_ref_dp.sv
module dram_ref_dp
  import dram_ref_pkg::*;
#(
  parameter int CLK_PER_REF = 3125,
  parameter int DEBT_MAX    = 8,
  parameter int ROW_W       = 8,
  parameter int ADDR_W      = 9,
  parameter bit RAS_ONLY    = 1'b0,
  parameter int PH_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  refStrobe_t        strb,
  output logic              owed,
  output logic [PH_W-1:0]   phase,
  output logic              rasN,
  output logic              casN,
  output logic              busy,
  output logic [ADDR_W-1:0] addr
);

  localparam int TMR_W  = $clog2(CLK_PER_REF + 1);
  localparam int DEBT_W = $clog2(DEBT_MAX + 1);
  localparam logic [TMR_W-1:0]  TMR_RELOAD = TMR_W'(CLK_PER_REF - 1);
  localparam logic [DEBT_W-1:0] DEBT_TOP   = DEBT_W'(DEBT_MAX);

  logic [TMR_W-1:0]  tmrCnt;
  logic [DEBT_W-1:0] debt;
  logic              tick;
  logic [ADDR_W-1:0] rowAddr;

  // interval timer
  assign tick = (tmrCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)     tmrCnt <= TMR_RELOAD;
    else if (tick) tmrCnt <= TMR_RELOAD;
    else           tmrCnt <= tmrCnt - 1'b1;
  end

  // saturating refresh debt
  always_ff @(posedge clk) begin
    if (!rstN) debt <= '0;
    else if (tick && !strb.done) begin
      if (debt != DEBT_TOP) debt <= debt + 1'b1;
    end else if (strb.done && !tick) begin
      debt <= debt - 1'b1;
    end
  end

  assign owed = (debt != '0);

  // cycles spent in the current state
  always_ff @(posedge clk) begin
    if (!rstN || strb.phaseClr) phase <= '0;
    else                        phase <= phase + 1'b1;
  end

  // row source depends on refresh style
  generate
    if (RAS_ONLY) begin : g_rowCnt
      logic [ROW_W-1:0] rowCnt;
      always_ff @(posedge clk) begin
        if (!rstN)          rowCnt <= '0;
        else if (strb.done) rowCnt <= rowCnt + 1'b1;
      end
      assign rowAddr = ADDR_W'(rowCnt);
    end else begin : g_noRow
      assign rowAddr = '0;
    end
  endgenerate

  // registered pin drivers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasN <= 1'b1;
      casN <= 1'b1;
      busy <= 1'b0;
      addr <= '0;
    end else begin
      rasN <= !strb.rasLow;
      casN <= !strb.casLow;
      busy <= strb.busy;
      addr <= strb.driveAddr ? rowAddr : '0;
    end
  end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_PER_REF  = 3125,
  parameter int DEBT_MAX     = 8,
  parameter int ROW_W        = 8,
  parameter int ADDR_W       = 9,
  parameter int SETUP_CYC    = 2,
  parameter int RAS_CYC      = 3,
  parameter int CAS_HOLD_CYC = 1,
  parameter int PRECHG_CYC   = 3,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refGrant,
  output logic              refReq,
  output logic              refBusy,
  output logic              rasN,
  output logic              casN,
  output logic [ADDR_W-1:0] addr
);

  localparam int PH_MAX = (SETUP_CYC > RAS_CYC) ?
                          ((SETUP_CYC > PRECHG_CYC) ? SETUP_CYC : PRECHG_CYC) :
                          ((RAS_CYC > PRECHG_CYC) ? RAS_CYC : PRECHG_CYC);
  localparam int PH_W = $clog2(PH_MAX + 1);

  refStrobe_t      strb;
  logic            owed;
  logic [PH_W-1:0] phase;

  dram_ref_ctrl #(
    .SETUP_CYC(SETUP_CYC), .RAS_CYC(RAS_CYC), .CAS_HOLD_CYC(CAS_HOLD_CYC),
    .PRECHG_CYC(PRECHG_CYC), .RAS_ONLY(RAS_ONLY), .PH_W(PH_W)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .owed(owed),
    .phase(phase), .strb(strb)
  );

  dram_ref_dp #(
    .CLK_PER_REF(CLK_PER_REF), .DEBT_MAX(DEBT_MAX), .ROW_W(ROW_W),
    .ADDR_W(ADDR_W), .RAS_ONLY(RAS_ONLY), .PH_W(PH_W)
  ) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .owed(owed), .phase(phase),
    .rasN(rasN), .casN(casN), .busy(refBusy), .addr(addr)
  );

  assign refReq = owed;

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int ADDR_W   = 9,
  parameter bit RAS_ONLY = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              refReq,
  input logic              refBusy,
  input logic              rasN,
  input logic              casN,
  input logic [ADDR_W-1:0] addr
);

  // R11
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refBusy |-> (rasN && casN && addr == '0));

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((RAS_ONLY == 1'b0) && $fell(rasN)) |-> (!casN && !$past(casN)));

  // R7
  ro_cas_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (RAS_ONLY == 1'b1) |-> casN);

  // R7
  row_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && !$past(rasN)) |-> $stable(addr));

  // R6
  cbr_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (RAS_ONLY == 1'b0) |-> (addr == '0));

  // R5
  ras_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> refBusy);

  // R9
  start_owed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refBusy) |-> $past(refReq));

endmodule

bind dram_refresh_sched dram_refresh_chk #(.ADDR_W(ADDR_W), .RAS_ONLY(RAS_ONLY)) chkI (
  .clk(clk), .rstN(rstN), .refReq(refReq), .refBusy(refBusy),
  .rasN(rasN), .casN(casN), .addr(addr)
);

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;

  localparam int P_CBR  = 100;
  localparam int P_RO   = 40;
  localparam int DMAX   = 8;
  localparam int AW     = 9;
  localparam int E0     = 3 * P_CBR - 5;   // grant edge so RAS rises on a tick
  localparam int RO_END = 10500;

  // {refBusy, rasN, casN} after edge E0+k
  localparam logic [2:0] CBR_WAVE [10] = '{
    3'b011, 3'b110, 3'b110, 3'b100, 3'b101,
    3'b101, 3'b111, 3'b111, 3'b111, 3'b011
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grantC = 1'b0, grantR = 1'b0;
  logic reqC, busyC, rasC, casC, reqR, busyR, rasR, casR;
  logic [AW-1:0] addrC, addrR;
  int cyc = 0;
  int nChk = 0, nFail = 0;
  int refCntC = 0, refCntR = 0;
  logic prevBusyC = 1'b0, prevRasC = 1'b1, prevRasR = 1'b1;
  logic [7:0] expRow = 8'd0;

  always #5 clk = ~clk;

  dram_refresh_sched #(.CLK_PER_REF(P_CBR), .DEBT_MAX(DMAX), .ADDR_W(AW),
                       .RAS_ONLY(1'b0)) dut (
    .clk(clk), .rstN(rstN), .refGrant(grantC), .refReq(reqC),
    .refBusy(busyC), .rasN(rasC), .casN(casC), .addr(addrC));

  dram_refresh_sched #(.CLK_PER_REF(P_RO), .DEBT_MAX(DMAX), .ADDR_W(AW),
                       .RAS_ONLY(1'b1)) dutRo (
    .clk(clk), .rstN(rstN), .refGrant(grantR), .refReq(reqR),
    .refBusy(busyR), .rasN(rasR), .casN(casR), .addr(addrR));

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  // refresh counting and per-refresh pin checks
  always @(negedge clk) begin
    if (rstN) begin
      if (busyC && !prevBusyC) refCntC++;
      if (!rasC && prevRasC) chk("R6 cbr addr", int'(addrC), 0);
      if (!rasR && prevRasR) begin
        refCntR++;
        chk("R7 ro cas high", int'(casR), 1);
        chk("R7/R8 ro row", int'(addrR), int'(expRow));
        expRow = expRow + 8'd1;
      end
      if (!busyR) chk("R11 idle pins", int'({rasR, casR}), 3);
    end
    prevBusyC = busyC;
    prevRasC  = rasC;
    prevRasR  = rasR;
  end

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 rasN", int'(rasC), 1);
    chk("R1 casN", int'(casC), 1);
    chk("R1 busy", int'(busyC), 0);
    chk("R1 req", int'(reqC), 0);
    chk("R1 addr", int'(addrR), 0);
    rstN = 1'b1;
    grantR = 1'b1;

    // R2: first request exactly one interval after reset
    waitCyc(P_CBR - 1);
    chk("R2 req before interval", int'(reqC), 0);
    waitCyc(P_CBR);
    chk("R2 req at interval", int'(reqC), 1);

    // R4/R5 waveform table, R10 tick on completion edge
    waitCyc(E0 - 1);
    base = refCntC;
    grantC = 1'b1;
    for (int k = 0; k < 10; k++) begin
      waitCyc(E0 + k);
      chk($sformatf("R4/R5 wave step %0d", k),
          int'({busyC, rasC, casC}), int'(CBR_WAVE[k]));
    end
    waitCyc(E0 + 13);
    chk("R9 req held while owed", int'(reqC), 1);
    waitCyc(E0 + 30);
    chk("R10 refreshes after collision", refCntC - base, 3);
    chk("R9 req cleared", int'(reqC), 0);
    chk("R11 busy released", int'(busyC), 0);
    grantC = 1'b0;

    // R3: debt saturates after nine intervals without grant
    waitCyc(12 * P_CBR);
    chk("R9 req with debt", int'(reqC), 1);
    base = refCntC;
    grantC = 1'b1;
    waitCyc(12 * P_CBR + 40);
    chk("R9 req mid catch-up", int'(reqC), 1);
    waitCyc(12 * P_CBR + 80);
    chk("R3 saturated refresh count", refCntC - base, DMAX);
    chk("R3 req after catch-up", int'(reqC), 0);
    grantC = 1'b0;
    waitCyc(13 * P_CBR);
    chk("R2 next interval", int'(reqC), 1);

    // R8: row counter wrap in the RAS-only instance
    waitCyc(RO_END);
    chk("R8 ro refreshes past wrap", int'(refCntR > 256), 1);
    chk("R8 ro refresh rate", refCntR, RO_END / P_RO);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule